// File: doc/BRIEF.md
# Panel Output Pixel Formatter

This block sits between a pixel receiver and a flat-panel output port 36 bits wide. Each cycle it samples one 24-bit pixel, a valid strobe, data enable, both syncs and three control bits. It registers them into an output word with its sideband signals. A pixel-width strap chooses between two formats. In the first, one full pixel goes out on each output clock. In the second, the pixels of a line are paired even/odd, each is cut to 18 bits, and a pair goes out on each output clock.

A clock-style strap decides whether the panel clock enable runs all the time or stops while data enable is low, as stop-clock panels need. Two active-low power-down inputs produce output-enable signals in place of tristate pads. The full power-down also clears all internal state. The output-only power-down leaves the internal state running and keeps two pins driven. A sync-detect output reports whether data enable is still toggling.

Top module: `panel_pixel_formatter`

## Requirements
- R1: With `dual_mode` low, every cycle with `in_valid` high gives, on the next cycle, `out_valid`=1 and `out_data`={12'h000, pixel}. Bits 35..24 are zero whenever `out_valid` is high in this mode.
- R2: With `dual_mode` high, pixels are counted only when both `in_valid` and `in_de` are high. Each pixel is cut to 18 bits as {p[23:18], p[15:10], p[7:2]}. On the cycle after an odd pixel is accepted, `out_data`={odd18, even18}, with the even pixel in bits 17..0 and the odd pixel in bits 35..18, and `out_valid`=1.
- R3: Pixel numbering restarts at even on each rising edge of `in_de`. When `in_de` falls with an unpaired even pixel held, the next cycle gives `out_data`={18'h0, even18} with `out_valid`=1.
- R4: `out_clk_en` is 1 when `stop_clk_mode` is 0. When `stop_clk_mode` is 1, `out_clk_en` equals `out_de`.
- R5: `oe_main` (data bus, clock, DE, syncs, control bits 2 and 3) is 1 only while both `pwr_down_n` and `out_off_n` are 1.
- R6: `oe_aux` (control bit 1 and sync detect) follows `pwr_down_n` alone and ignores `out_off_n`.
- R7: While `pwr_down_n` is 0, all registers are cleared at each clock. A held unpaired pixel is discarded and `sync_det` drops. `out_off_n` alone changes no internal state.
- R8: `sync_det` is 1 on the cycle after `in_de` changes value. It goes to 0 once `IDLE_CYCLES` consecutive clocks have passed with no change.
- R9: `out_de`, `out_hs`, `out_vs` and `out_ctl` repeat their inputs one clock later, the same latency as the data word.
- R10: After reset all registered outputs, including `sync_det`, are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_down_n | input | 1 | Full power-down, active low |
| out_off_n | input | 1 | Output-only power-down, active low |
| dual_mode | input | 1 | 0: one pixel per word, 1: even/odd pair per word |
| stop_clk_mode | input | 1 | 1: clock enable stops while DE is low |
| in_valid | input | 1 | Input pixel strobe |
| in_pix | input | 24 | Input pixel, 8 bits per colour |
| in_de | input | 1 | Input data enable |
| in_hs | input | 1 | Input horizontal sync |
| in_vs | input | 1 | Input vertical sync |
| in_ctl | input | 3 | Input control bits |
| out_data | output | 36 | Output data word |
| out_valid | output | 1 | Output word strobe |
| out_clk_en | output | 1 | Panel clock enable |
| out_de | output | 1 | Delayed data enable |
| out_hs | output | 1 | Delayed horizontal sync |
| out_vs | output | 1 | Delayed vertical sync |
| out_ctl | output | 3 | Delayed control bits |
| oe_main | output | 1 | Enable for data, clock, DE, syncs, control bits 2 and 3 |
| oe_aux | output | 1 | Enable for control bit 1 and sync detect |
| sync_det | output | 1 | DE activity indicator |

## Verification
The data word, its strobe, the sideband copies and the sync-detect flag are all due exactly one clock after the inputs that cause them. The flush word is due one clock after the falling DE. The two output enables and the clock enable depend on the straps and on `out_de` in the same cycle. Sync detect falls `IDLE_CYCLES` clocks after the last DE change, which the bench reaches with a shortened idle parameter. A behavioural model updates on each rising edge from the same sampled inputs, and every output is compared 3 ns after that edge. At that point the registered results have settled and the inputs, which change on the falling edge, are still stable.

// File: rtl/panel_pixel_formatter.sv
module panel_pixel_formatter #(
  parameter int IDLE_CYCLES = 2048
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pwr_down_n,
  input  logic        out_off_n,
  input  logic        dual_mode,
  input  logic        stop_clk_mode,
  input  logic        in_valid,
  input  logic [23:0] in_pix,
  input  logic        in_de,
  input  logic        in_hs,
  input  logic        in_vs,
  input  logic [2:0]  in_ctl,
  output logic [35:0] out_data,
  output logic        out_valid,
  output logic        out_clk_en,
  output logic        out_de,
  output logic        out_hs,
  output logic        out_vs,
  output logic [2:0]  out_ctl,
  output logic        oe_main,
  output logic        oe_aux,
  output logic        sync_det
);
  localparam int CW = $clog2(IDLE_CYCLES + 1);
  localparam logic [CW-1:0] IDLE_V = CW'(IDLE_CYCLES);

  logic [17:0]   half_q;
  logic          pend_q;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [17:0]   cut;
  logic          rise, fall, held;

  assign cut   = {in_pix[23:18], in_pix[15:10], in_pix[7:2]};
  assign rise  = in_de & ~out_de;
  assign fall  = ~in_de & out_de;
  assign held  = pend_q & ~rise;
  assign cnt_n = (in_de != out_de) ? '0 : (cnt_q == IDLE_V) ? IDLE_V : cnt_q + 1'b1;

  assign out_clk_en = ~stop_clk_mode | out_de;
  assign oe_main    = pwr_down_n & out_off_n;
  assign oe_aux     = pwr_down_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data <= '0; out_valid <= 1'b0; half_q <= '0; pend_q <= 1'b0;
      out_de <= 1'b0; out_hs <= 1'b0; out_vs <= 1'b0; out_ctl <= '0;
      cnt_q <= IDLE_V; sync_det <= 1'b0;
    end else if (!pwr_down_n) begin
      out_data <= '0; out_valid <= 1'b0; half_q <= '0; pend_q <= 1'b0;
      out_de <= 1'b0; out_hs <= 1'b0; out_vs <= 1'b0; out_ctl <= '0;
      cnt_q <= IDLE_V; sync_det <= 1'b0;
    end else begin
      out_de    <= in_de;
      out_hs    <= in_hs;
      out_vs    <= in_vs;
      out_ctl   <= in_ctl;
      cnt_q     <= cnt_n;
      sync_det  <= cnt_n != IDLE_V;
      out_valid <= 1'b0;
      if (!dual_mode) begin
        pend_q <= 1'b0;
        if (in_valid) begin
          out_data  <= {12'h000, in_pix};
          out_valid <= 1'b1;
        end
      end else if (in_valid && in_de) begin
        if (held) begin
          out_data  <= {cut, half_q};
          out_valid <= 1'b1;
          pend_q    <= 1'b0;
        end else begin
          half_q <= cut;
          pend_q <= 1'b1;
        end
      end else if (fall && pend_q) begin
        out_data  <= {18'h0, half_q};
        out_valid <= 1'b1;
        pend_q    <= 1'b0;
      end
    end
  end
endmodule

module panel_pixel_formatter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        pwr_down_n,
  input logic        out_off_n,
  input logic        dual_mode,
  input logic        stop_clk_mode,
  input logic        in_de,
  input logic [35:0] out_data,
  input logic        out_valid,
  input logic        out_clk_en,
  input logic        out_de,
  input logic        oe_main,
  input logic        oe_aux,
  input logic        sync_det
);
  p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !$past(dual_mode) |-> out_data[35:24] == 12'h000);
  p_clk_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stop_clk_mode && !out_de |-> !out_clk_en);
  p_off_main_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !out_off_n |-> !oe_main);
  p_aux_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down_n |-> oe_aux);
  p_pd_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_down_n |=> !out_valid && !out_de && !sync_det);
  p_edge_seen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down_n && (in_de != out_de) |=> sync_det);
  p_de_align_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down_n && in_de |=> out_de);
endmodule

bind panel_pixel_formatter panel_pixel_formatter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_down_n(pwr_down_n), .out_off_n(out_off_n),
  .dual_mode(dual_mode), .stop_clk_mode(stop_clk_mode), .in_de(in_de),
  .out_data(out_data), .out_valid(out_valid), .out_clk_en(out_clk_en),
  .out_de(out_de), .oe_main(oe_main), .oe_aux(oe_aux), .sync_det(sync_det));

// File: tb/sim_panel_pixel_formatter.sv
`timescale 1ns/1ps
module sim_panel_pixel_formatter;
  localparam int IDLE = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0, pd_n = 1'b1, off_n = 1'b1, dual = 1'b0, stopc = 1'b0;
  logic v = 1'b0, de = 1'b0, hs = 1'b0, vs = 1'b0;
  logic [23:0] pix = '0;
  logic [2:0]  ctl = '0;
  logic [35:0] o_data;
  logic o_valid, o_cke, o_de, o_hs, o_vs, o_oe, o_aux, o_sd;
  logic [2:0] o_ctl;

  int checks = 0, errors = 0;
  bit done = 0;
  string tag = "R10";

  always #5 clk = ~clk;

  panel_pixel_formatter #(.IDLE_CYCLES(IDLE)) u0 (
    .clk(clk), .rst_n(rst_n), .pwr_down_n(pd_n), .out_off_n(off_n),
    .dual_mode(dual), .stop_clk_mode(stopc), .in_valid(v), .in_pix(pix),
    .in_de(de), .in_hs(hs), .in_vs(vs), .in_ctl(ctl),
    .out_data(o_data), .out_valid(o_valid), .out_clk_en(o_cke), .out_de(o_de),
    .out_hs(o_hs), .out_vs(o_vs), .out_ctl(o_ctl), .oe_main(o_oe),
    .oe_aux(o_aux), .sync_det(o_sd));

  function automatic logic [17:0] top6(input logic [23:0] p);
    return {p[23:18], p[15:10], p[7:2]};
  endfunction

  // reference model
  logic [35:0] m_data = '0;
  logic m_valid = 0, m_de = 0, m_hs = 0, m_vs = 0, m_sd = 0;
  logic [2:0] m_ctl = '0;
  int m_idle = IDLE;
  int pair_q[$];
  logic [17:0] first_px;

  always @(posedge clk) begin
    if (!rst_n || !pd_n) begin
      m_data = '0; m_valid = 0; m_de = 0; m_hs = 0; m_vs = 0; m_ctl = '0;
      m_idle = IDLE; m_sd = 0; pair_q.delete();
    end else begin
      m_valid = 0;
      if (!dual) begin
        pair_q.delete();
        if (v) begin m_data = {12'h000, pix}; m_valid = 1; end
      end else if (v && de) begin
        if (de && !m_de) pair_q.delete();
        pair_q.push_back(top6(pix));
        if (pair_q.size() == 2) begin
          first_px = 18'(pair_q.pop_front());
          m_data = {top6(pix), first_px};
          m_valid = 1;
          pair_q.delete();
        end
      end else if (!de && m_de && pair_q.size() == 1) begin
        m_data = {18'h0, 18'(pair_q.pop_front())};
        m_valid = 1;
      end
      if (de != m_de) m_idle = 0;
      else if (m_idle < IDLE) m_idle++;
      m_sd = m_idle < IDLE;
      m_de = de; m_hs = hs; m_vs = vs; m_ctl = ctl;
    end
  end

  task automatic chk(input string r, input string what, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", r, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #3;
    if (!done) begin
      chk(tag, "valid", 36'(o_valid), 36'(m_valid));
      if (m_valid) chk(tag, "data", o_data, m_data);
      chk(rst_n ? "R9" : "R10", "de", 36'(o_de), 36'(m_de));
      chk(rst_n ? "R9" : "R10", "syncs", 36'({o_hs, o_vs, o_ctl}), 36'({m_hs, m_vs, m_ctl}));
      chk("R4", "clk_en", 36'(o_cke), 36'(!stopc || m_de));
      chk("R5", "oe_main", 36'(o_oe), 36'(pd_n && off_n));
      chk("R6", "oe_aux", 36'(o_aux), 36'(pd_n));
      chk(rst_n ? "R8" : "R10", "sync_det", 36'(o_sd), 36'(m_sd));
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic line(input int n, input bit gaps);
    int sent = 0;
    int i = 0;
    while (sent < n) begin
      de = 1; hs = 0; vs = (i == 0); ctl = 3'(i);
      v = !(gaps && (i % 3 == 2));
      pix = 24'($urandom);
      if (v) sent++;
      i++;
      step();
    end
    v = 0; de = 0; hs = 1; ctl = 3'b101;
    repeat (4) step();
    hs = 0;
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1;
    step();
    tag = "R1";  dual = 0; line(5, 1); line(3, 0);
    tag = "R2";  dual = 1; line(6, 0); line(8, 1);
    tag = "R3";  line(5, 0); line(1, 0); line(7, 1);
    tag = "R4";  stopc = 1; line(4, 0); dual = 0; line(3, 1); stopc = 0;
    tag = "R7";  dual = 1;
    de = 1; v = 1; pix = 24'hA5C3F0; step();
    v = 0; off_n = 0; repeat (3) step(); off_n = 1;
    v = 1; pix = 24'h123456; step();
    v = 1; pix = 24'hFEDCBA; step();
    v = 0; pd_n = 0; repeat (2) step(); pd_n = 1;
    v = 1; pix = 24'h0F0F0F; step();
    v = 0; de = 0; repeat (3) step();
    tag = "R8";  repeat (IDLE + 6) step();
    line(2, 0);
    off_n = 0; repeat (IDLE + 3) step(); off_n = 1;
    tag = "R1";  dual = 0; line(4, 0);
    repeat (3) step();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule